// File: doc/BRIEF.md
# Pipeline Bubble Penalty Counter

This unit watches a five-stage pipeline's control strobes and keeps running counts for performance analysis. Each enabled cycle it advances a cycle counter. It also counts retired instructions. It tracks the bubbles charged to each of three hazard causes: a stall where a load feeds the next instruction costs one bubble, a wrongly predicted conditional branch costs two, and a subroutine return costs three. Software reads the counts through a small registered read port and works out the cycles-per-instruction figure itself, as one plus bubbles over instructions.

When every cycle of a run is either a retirement or a bubble, the cycle count equals instructions plus bubbles. An audit strobe compares the two sides of that equation and leaves the result on a flag. The flag then reveals strobes that were lost, doubled or mis-attributed somewhere in the pipeline control.

Top module: `perf_bubble_meter`

## Requirements
- R1: Reset or the synchronous `clr` input zeroes all five counters and the `mismatch` flag on the next edge; `clr` wins over counting and over an audit in the same cycle.
- R2: While `en` is high the cycle counter rises by exactly 1 per clock.
- R3: While `en` is high the retired-instruction counter rises by 1 in each cycle that `ev_retire` is high.
- R4: While `en` is high the load-use counter rises by 1 in each cycle that `ev_loaduse` is high.
- R5: While `en` is high the mispredict counter rises by 2 in each cycle that `ev_mispredict` is high.
- R6: While `en` is high the return counter rises by 3 in each cycle that `ev_return` is high; all strobes may be high together and each counter steps independently.
- R7: While `en` is low no counter changes, whatever the strobes do.
- R8: Every counter saturates at all ones (255 when W is 8) and never wraps.
- R9: `rd_data` shows, one clock after `rd_addr` is presented, the selected value: 0 cycles, 1 retired, 2 load-use, 3 mispredict, 4 return, 5 the sum of the three bubble counters saturated at all ones, 6 and 7 zero.
- R10: One clock after `audit` is high, `mismatch` is 1 exactly when the cycle count differs from retired plus all three bubble counts, taken at full precision; without `audit` or `clr` the flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and flag |
| en | input | 1 | Counting enable |
| ev_retire | input | 1 | An instruction retired this cycle |
| ev_loaduse | input | 1 | Load-use stall inserted this cycle |
| ev_mispredict | input | 1 | Conditional branch mispredict resolved this cycle |
| ev_return | input | 1 | Return instruction processed this cycle |
| audit | input | 1 | Sample the accounting identity |
| rd_addr | input | 3 | Counter select |
| rd_data | output | W | Selected value, one cycle after the select |
| mismatch | output | 1 | Accounting identity failed at the last audit |

## Verification
A wrong step size or enable gating in any counter shows as a wrong `rd_data` value on the first read after the faulty cycles, one clock after the select. Saturation faults appear only after long runs, so the bench drives more than 255 events at a narrow width. A faulty identity comparator shows on `mismatch` one clock after an audit. Both consistent runs and deliberately inconsistent runs are audited, so the flag is seen in both directions.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
package pbm_pkg;
  localparam int NCNT = 5;
  localparam int STEPW = 2;

  localparam int unsigned COST_LOADUSE = 1;
  localparam int unsigned COST_MISPRED = 2;
  localparam int unsigned COST_RETURN  = 3;

  typedef enum logic [2:0] {
    SEL_CYCLES  = 3'd0,
    SEL_RETIRED = 3'd1,
    SEL_LOADUSE = 3'd2,
    SEL_MISPRED = 3'd3,
    SEL_RETURN  = 3'd4,
    SEL_BUBBLES = 3'd5
  } sel_e;

  function automatic int unsigned step_cost(input int idx);
    case (idx)
      2:       return COST_LOADUSE;
      3:       return COST_MISPRED;
      4:       return COST_RETURN;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/pbm_sat_counter.sv
`timescale 1ns/1ps
module pbm_sat_counter #(
  parameter int W  = 32,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [SW-1:0] step,
  output logic [W-1:0]  q
);
  localparam int PADW = W + 1 - SW;

  logic [W:0] sum;
  assign sum = {1'b0, q} + {{PADW{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (en && (step != '0)) begin
      q <= sum[W] ? '1 : sum[W-1:0];
    end
  end
endmodule

// File: rtl/pbm_audit.sv
`timescale 1ns/1ps
module pbm_audit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         audit,
  input  logic [W-1:0] cyc,
  input  logic [W-1:0] ins,
  input  logic [W-1:0] lu,
  input  logic [W-1:0] mp,
  input  logic [W-1:0] rt,
  output logic [W-1:0] bub_total,
  output logic         mismatch
);
  localparam int BW = W + 2;
  localparam int TW = W + 3;

  logic [BW-1:0] bub_full;
  logic [TW-1:0] want;
  logic [TW-1:0] have;

  assign bub_full  = {2'b00, lu} + {2'b00, mp} + {2'b00, rt};
  assign want      = {3'b000, ins} + {1'b0, bub_full};
  assign have      = {3'b000, cyc};
  assign bub_total = (|bub_full[BW-1:W]) ? '1 : bub_full[W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mismatch <= 1'b0;
    end else if (audit) begin
      mismatch <= (have != want);
    end
  end
endmodule

// File: rtl/pbm_rdport.sv
`timescale 1ns/1ps
module pbm_rdport #(
  parameter int W = 32,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   addr,
  input  logic [W-1:0] cnt [N],
  input  logic [W-1:0] bub_total,
  output logic [W-1:0] rd_data
);
  import pbm_pkg::*;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < N; i++) begin
      if (addr == 3'(i)) nxt = cnt[i];
    end
    if (addr == SEL_BUBBLES) nxt = bub_total;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= nxt;
  end
endmodule

// File: rtl/perf_bubble_meter.sv
`timescale 1ns/1ps
module perf_bubble_meter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         ev_retire,
  input  logic         ev_loaduse,
  input  logic         ev_mispredict,
  input  logic         ev_return,
  input  logic         audit,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         mismatch
);
  import pbm_pkg::*;

  logic [NCNT-1:0]  hit;
  logic [STEPW-1:0] step    [NCNT];
  logic [W-1:0]     cnt_val [NCNT];
  logic [W-1:0]     bub_total;

  // index order: cycles, retired, load-use, mispredict, return
  assign hit = {ev_return, ev_mispredict, ev_loaduse, ev_retire, 1'b1};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    assign step[g] = hit[g] ? STEPW'(step_cost(g)) : '0;

    pbm_sat_counter #(.W(W), .SW(STEPW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .en   (en),
      .step (step[g]),
      .q    (cnt_val[g])
    );
  end

  pbm_audit #(.W(W)) u_audit (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .audit     (audit),
    .cyc       (cnt_val[0]),
    .ins       (cnt_val[1]),
    .lu        (cnt_val[2]),
    .mp        (cnt_val[3]),
    .rt        (cnt_val[4]),
    .bub_total (bub_total),
    .mismatch  (mismatch)
  );

  pbm_rdport #(.W(W), .N(NCNT)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr      (rd_addr),
    .cnt       (cnt_val),
    .bub_total (bub_total),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/pbm_checker.sv
`timescale 1ns/1ps
module pbm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         clr,
  input logic         en,
  input logic         audit,
  input logic [2:0]   rd_addr,
  input logic [W-1:0] rd_data,
  input logic         mismatch,
  input logic [W-1:0] cyc
);
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
    clr |=> !mismatch); // R1

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && (cyc != '1)) |=> (cyc == $past(cyc) + 1'b1)); // R2

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cyc)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ((cyc == '1) && !clr) |=> (cyc == '1)); // R8

  AST_RD_BLANK: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= 3'd6) |=> (rd_data == '0)); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!audit && !clr) |=> $stable(mismatch)); // R10
endmodule

bind perf_bubble_meter pbm_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .en       (en),
  .audit    (audit),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .mismatch (mismatch),
  .cyc      (cnt_val[0])
);

// File: tb/perf_bubble_meter_test.sv
`timescale 1ns/1ps
module perf_bubble_meter_test;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst = 1, clr = 0, en = 0, audit = 0;
  logic ev_retire = 0, ev_loaduse = 0, ev_mispredict = 0, ev_return = 0;
  logic [2:0]   rd_addr = 0;
  logic [W-1:0] rd_data;
  logic         mismatch;

  always #2 clk = ~clk;

  perf_bubble_meter #(.W(W)) uut (
    .clk(clk), .rst(rst), .clr(clr), .en(en),
    .ev_retire(ev_retire), .ev_loaduse(ev_loaduse),
    .ev_mispredict(ev_mispredict), .ev_return(ev_return),
    .audit(audit), .rd_addr(rd_addr), .rd_data(rd_data), .mismatch(mismatch)
  );

  typedef struct { int expv; int due; string tag; } item_t;
  item_t sbq[$];

  int n_chk = 0, n_fail = 0, tb_cyc = 0;
  int m[5];
  bit mm = 0;
  bit done = 0;

  always @(posedge clk) tb_cyc <= tb_cyc + 1;

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(input int act, input int expv, input string tag);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int model_read(input int a);
    if (a < 5)  return m[a];
    if (a == 5) return sat(m[2] + m[3] + m[4]);
    return 0;
  endfunction

  // monitor: pops scoreboard items when their result is due
  item_t cur;
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == tb_cyc) begin
      cur = sbq.pop_front();
      chk(int'(rd_data), cur.expv, cur.tag);
    end
  end

  task automatic idle_inputs();
    en = 0; clr = 0; audit = 0;
    ev_retire = 0; ev_loaduse = 0; ev_mispredict = 0; ev_return = 0;
  endtask

  task automatic tick(input bit e, input bit r, input bit l, input bit p,
                      input bit t, input bit a, input bit c);
    @(negedge clk);
    en = e; ev_retire = r; ev_loaduse = l; ev_mispredict = p; ev_return = t;
    audit = a; clr = c;
    if (c) begin
      for (int i = 0; i < 5; i++) m[i] = 0;
      mm = 0;
    end else begin
      if (a) mm = (m[0] != m[1] + m[2] + m[3] + m[4]);
      if (e) begin
        m[0] = sat(m[0] + 1);
        if (r) m[1] = sat(m[1] + 1);
        if (l) m[2] = sat(m[2] + 1);
        if (p) m[3] = sat(m[3] + 2);
        if (t) m[4] = sat(m[4] + 3);
      end
    end
  endtask

  // driver: present a select and push the expected value
  task automatic rd(input int a, input string tag);
    item_t it;
    @(negedge clk);
    idle_inputs();
    rd_addr = 3'(a);
    it.expv = model_read(a);
    it.due  = tb_cyc + 1;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 8; a++) rd(a, tag);
  endtask

  task automatic flag(input string tag);
    @(negedge clk);
    idle_inputs();
    chk(int'(mismatch), int'(mm), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) m[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: reset state
    rd_all("R1");
    flag("R1");

    // consistent run: every cycle is a retirement or a bubble
    repeat (6) tick(1, 1, 0, 0, 0, 0, 0);
    tick(1, 0, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0, 0);
    tick(1, 0, 0, 1, 0, 0, 0);
    tick(1, 0, 0, 0, 0, 0, 0);
    repeat (3) tick(1, 1, 0, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 1, 0, 0);
    repeat (2) tick(1, 0, 0, 0, 0, 0, 0);
    repeat (2) tick(1, 1, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    flag("R10");
    rd(0, "R2"); rd(1, "R3"); rd(2, "R4"); rd(3, "R5"); rd(4, "R6");
    rd(5, "R9"); rd(6, "R9"); rd(7, "R9");

    // R7: strobes with enable low
    repeat (5) tick(0, 1, 1, 1, 1, 0, 0);
    for (int a = 0; a < 5; a++) rd(a, "R7");
    flag("R10");

    // inconsistent: mispredict with no idle follow-up cycle
    tick(1, 0, 0, 1, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    flag("R10");
    repeat (3) tick(1, 1, 0, 0, 0, 0, 0);
    flag("R10");

    // all strobes together
    tick(1, 1, 1, 1, 1, 0, 0);
    rd(1, "R3"); rd(2, "R4"); rd(3, "R5"); rd(4, "R6"); rd(5, "R9");

    // R1: clear beats counting and audit
    tick(1, 1, 1, 1, 1, 1, 1);
    rd_all("R1");
    flag("R1");

    // R8: saturation
    repeat (300) tick(1, 1, 0, 0, 0, 0, 0);
    repeat (90)  tick(1, 0, 0, 0, 1, 0, 0);
    repeat (130) tick(1, 0, 0, 1, 0, 0, 0);
    rd_all("R8");
    tick(0, 0, 0, 0, 0, 1, 0);
    flag("R10");

    repeat (3) @(negedge clk);
    chk(sbq.size(), 0, "R9");
    finish_run();
  end
endmodule